// File: doc/BRIEF.md
# Clock-Ratio Pulse Counter

This block turns the pulse train of a frequency-output analog converter into a digital code. It counts rising pulse edges over a gate window. The window is timed from the same reference clock that drives the converter, so the code is the ratio of pulse rate to clock rate. Clock jitter and drift therefore cancel out of the result. At full scale the pulse rate is half the clock rate, and a conversion with N output codes keeps the gate open for 2N clock cycles. With that gate length, full scale lands at exactly N counts.

Software or a sequencer picks one of five code counts with a select input. Three are binary (4096, 16384 and 65536) and two are decimal (10000 and 20000). It then pulses a start strobe. The block raises busy while the gate is open. When the gate closes, it latches the count and the overrange flag into output registers and pulses done for one cycle. Choosing the clock rate so that the gate time is a whole number of 50, 60 or 400 Hz line periods rejects those line frequencies. An example is 16384 codes at 327.68 kHz, which gives a 100 ms gate.

The parameter CODE_SHIFT divides every code count by 2^CODE_SHIFT. This allows shorter gates in test builds. The production default is 0.

Top module: `gated_pulse_counter`

## Requirements
- R1: The 3-bit resSel sampled with an accepted start picks the code count N, each value divided by 2^CODE_SHIFT: 0 gives 4096, 1 gives 16384, 2 gives 65536, 3 gives 10000, 4 gives 20000, and 5 to 7 give 4096.
- R2: After the clock edge that accepts a start, busy is high for exactly 2N consecutive clock cycles.
- R3: pulseIn passes through a two-flop synchronizer. The result equals the number of rising edges of the synchronized pulse seen on the 2N clock edges that follow the accepting edge.
- R4: The count never exceeds N-1. A pulse that would take it to N leaves it at N-1 and sets overrange for that conversion.
- R5: done is high for exactly one cycle, the first cycle in which busy is low after a gate. result and overrange take their new values in that same cycle.
- R6: result and overrange hold their values from one completed conversion until the next one completes, including while the next gate is open.
- R7: A start that is high while busy is high, including in the last busy cycle, is ignored. It changes neither the gate length nor the selected N, and starts no new conversion.
- R8: While rstN is low, busy, done, overrange and result are all zero.
- R9: Pulses that occur while no gate is open do not reach the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock shared with the analog converter |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseIn | input | 1 | Asynchronous pulse train from the converter |
| start | input | 1 | Begins a conversion when sampled high while idle |
| resSel | input | 3 | Code count select (see R1) |
| result | output | CNT_W | Latched count from the last conversion (CNT_W = log2 of the largest N) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while the gate is open |
| overrange | output | 1 | Latched saturation flag from the last conversion |

## Verification
The bench builds the block with CODE_SHIFT = 4. This cuts the gates to between 512 and 8192 cycles, so it can sweep every select value, including the reserved ones and both decimal counts, and still run a large number of conversions. At this scale a pulse train at half the clock rate drives the count into saturation within a few hundred cycles. Starts placed at the gate's first and last cycles, and pulses that end just ahead of a gate, fall within a short run. A behavioural model that counts synchronized edges is compared with all four outputs on every cycle. Directed checks pin down exact counts where the pulse phase makes them fixed.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef struct packed {
    logic clear;  // start accepted: zero the running count
    logic gate;   // gate open on this edge
    logic close;  // final gate edge: latch the result
  } gateStrobes_t;

  function automatic int unsigned maxCodes(input int unsigned shift);
    return 32'd65536 >> shift;
  endfunction

  function automatic int unsigned codesFor(input logic [2:0] sel, input int unsigned shift);
    int unsigned base;
    case (sel)
      3'd1:    base = 16384;
      3'd2:    base = 65536;
      3'd3:    base = 10000;
      3'd4:    base = 20000;
      default: base = 4096;
    endcase
    return base >> shift;
  endfunction

endpackage

// File: rtl/gpc_ctrl.sv
module gpc_ctrl #(
  parameter int CODE_SHIFT = 0,
  parameter int LIM_W      = 17
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [2:0]           resSel,
  output gpc_pkg::gateStrobes_t strobes,
  output logic [LIM_W-1:0]     limit,
  output logic                 busy,
  output logic                 done
);
  localparam int TMR_W = LIM_W;

  logic [LIM_W-1:0] limitQ;
  logic [LIM_W-1:0] selLimit;
  logic [LIM_W:0]   gateLen;
  logic [TMR_W-1:0] timerQ;
  logic             busyQ;
  logic             doneQ;
  logic             startOk;
  logic             lastEdge;

  assign selLimit = LIM_W'(gpc_pkg::codesFor(resSel, CODE_SHIFT));
  assign gateLen  = {selLimit, 1'b0};
  assign startOk  = start && !busyQ;
  assign lastEdge = busyQ && (timerQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      timerQ <= '0;
      limitQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (startOk) begin
        busyQ  <= 1'b1;
        limitQ <= selLimit;
        timerQ <= TMR_W'(gateLen - (LIM_W+1)'(1));
      end else if (busyQ) begin
        if (timerQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          timerQ <= timerQ - TMR_W'(1);
        end
      end
    end
  end

  assign strobes.clear = startOk;
  assign strobes.gate  = busyQ;
  assign strobes.close = lastEdge;
  assign limit = limitQ;
  assign busy  = busyQ;
  assign done  = doneQ;

  // Gate-length watch counter, independent of the down-counting timer.
  logic [LIM_W:0] gateSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        gateSeen <= '0;
    else if (startOk) gateSeen <= '0;
    else if (busyQ)   gateSeen <= gateSeen + (LIM_W+1)'(1);
  end

  p_gate_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (gateSeen == {limitQ, 1'b0}));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  p_done_after_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && (timerQ != '0)) |=> (busyQ && $stable(limitQ)));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && (timerQ == '0)) |=> !busyQ);

endmodule

// File: rtl/gpc_datapath.sv
module gpc_datapath #(
  parameter int CNT_W = 16,
  parameter int LIM_W = 17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pulseIn,
  input  gpc_pkg::gateStrobes_t strobes,
  input  logic [LIM_W-1:0]      limit,
  output logic [CNT_W-1:0]      result,
  output logic                  overrange
);
  logic [1:0]       syncQ;
  logic             prevQ;
  logic             risingEdge;
  logic             hit;
  logic             atTop;
  logic [CNT_W-1:0] countQ;
  logic             ovrRunQ;
  logic [CNT_W-1:0] resultQ;
  logic             ovrQ;

  assign risingEdge = syncQ[1] && !prevQ;
  assign hit        = strobes.gate && risingEdge;
  assign atTop      = (LIM_W'(countQ) == (limit - LIM_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pulseIn};
      prevQ <= syncQ[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      ovrRunQ <= 1'b0;
    end else if (strobes.clear) begin
      countQ  <= '0;
      ovrRunQ <= 1'b0;
    end else if (hit) begin
      if (atTop) ovrRunQ <= 1'b1;
      else       countQ  <= countQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      ovrQ    <= 1'b0;
    end else if (strobes.close) begin
      resultQ <= (hit && !atTop) ? countQ + CNT_W'(1) : countQ;
      ovrQ    <= ovrRunQ || (hit && atTop);
    end
  end

  assign result    = resultQ;
  assign overrange = ovrQ;

  p_count_below_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gate |-> (LIM_W'(countQ) < limit));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.close |=> ($stable(resultQ) && $stable(ovrQ)));

  p_clear_on_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (countQ == '0) && !ovrRunQ);

endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter #(
  parameter int CODE_SHIFT = 0,
  localparam int CNT_W = $clog2(gpc_pkg::maxCodes(CODE_SHIFT))
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic             start,
  input  logic [2:0]       resSel,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             busy,
  output logic             overrange
);
  localparam int LIM_W = CNT_W + 1;

  gpc_pkg::gateStrobes_t strobes;
  logic [LIM_W-1:0]      limit;

  gpc_ctrl #(.CODE_SHIFT(CODE_SHIFT), .LIM_W(LIM_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .resSel  (resSel),
    .strobes (strobes),
    .limit   (limit),
    .busy    (busy),
    .done    (done)
  );

  gpc_datapath #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pulseIn   (pulseIn),
    .strobes   (strobes),
    .limit     (limit),
    .result    (result),
    .overrange (overrange)
  );

endmodule

// File: tb/tb_gated_pulse_counter.sv
`timescale 1ns/1ps
module tb_gated_pulse_counter;
  localparam int SHIFT = 4;
  localparam int RW = $clog2(65536 >> SHIFT);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseIn = 1'b0;
  logic start = 1'b0;
  logic [2:0] resSel = 3'd0;
  logic [RW-1:0] result;
  logic done, busy, overrange;

  int nChecks = 0;
  int nFail = 0;
  int genPer = 0;
  bit monOn = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gated_pulse_counter #(.CODE_SHIFT(SHIFT)) dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .start(start), .resSel(resSel),
    .result(result), .done(done), .busy(busy), .overrange(overrange)
  );

  // R1: code count per select value, scaled by 2^SHIFT
  function automatic int expCodes(input int sel);
    case (sel)
      1: return 16384 >> SHIFT;
      2: return 65536 >> SHIFT;
      3: return 10000 >> SHIFT;
      4: return 20000 >> SHIFT;
      default: return 4096 >> SHIFT;
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mBusy, mDone, mRes, mOvrQ, mCnt, mOvr, mLeft, mN, s1, s2, s3;
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mRes = 0; mOvrQ = 0; mCnt = 0; mOvr = 0;
      mLeft = 0; mN = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int evt, wasBusy;
      evt = (s2 == 1 && s3 == 0) ? 1 : 0;
      wasBusy = mBusy;
      mDone = 0;
      if (mBusy == 1) begin
        if (evt == 1) begin
          if (mCnt == mN - 1) mOvr = 1;
          else mCnt++;
        end
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1; mRes = mCnt; mOvrQ = mOvr;
        end
      end
      if (start && wasBusy == 0) begin
        mN = expCodes(int'(resSel));
        mLeft = 2 * mN; mBusy = 1; mCnt = 0; mOvr = 0;
      end
      s3 = s2; s2 = s1; s1 = int'(pulseIn);
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (monOn && rstN) begin
      nChecks++;
      if (int'(busy) != mBusy) begin nFail++; $display("FAIL R2 busy actual=%0d expected=%0d", busy, mBusy); end
      else if (int'(done) != mDone) begin nFail++; $display("FAIL R5 done actual=%0d expected=%0d", done, mDone); end
      else if (int'(result) != mRes) begin nFail++; $display("FAIL R3 result actual=%0d expected=%0d", result, mRes); end
      else if (int'(overrange) != mOvrQ) begin nFail++; $display("FAIL R4 overrange actual=%0d expected=%0d", overrange, mOvrQ); end
    end
  end

  // Pulse generator: genPer cycles per period, 0 or 1 means quiet
  initial begin
    forever begin
      if (genPer < 2) begin
        pulseIn = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = genPer;
        pulseIn = 1'b1;
        repeat (p / 2) @(negedge clk);
        pulseIn = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic runConv(input int sel, output int len);
    start = 1'b1; resSel = 3'(sel);
    @(negedge clk);
    start = 1'b0;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int len, held;
    repeat (5) @(negedge clk);
    // R8: reset state
    check("R8 busy in reset", busy, 0);
    check("R8 done in reset", done, 0);
    check("R8 result in reset", result, 0);
    check("R8 overrange in reset", overrange, 0);
    rstN = 1'b1;
    monOn = 1;
    repeat (3) @(negedge clk);

    // R1, R2, R5, R9: every select value with a quiet pulse input
    for (int s = 0; s < 8; s++) begin
      runConv(s, len);
      check($sformatf("R1 R2 gate length sel=%0d", s), len, 2 * expCodes(s));
      check("R5 done at gate close", done, 1);
      check("R9 quiet input gives zero", result, 0);
      @(negedge clk);
      check("R5 done single cycle", done, 0);
    end

    // R3: exact counts with steady periodic pulses
    genPer = 4; repeat (10) @(negedge clk);
    runConv(0, len);
    check("R3 period 4 sel 0 count", result, (2 * expCodes(0)) / 4);
    check("R4 no overrange at half load", overrange, 0);
    genPer = 8; repeat (12) @(negedge clk);
    runConv(1, len);
    check("R3 period 8 sel 1 count", result, (2 * expCodes(1)) / 8);

    // R4: full-rate pulses saturate
    genPer = 2; repeat (10) @(negedge clk);
    runConv(0, len);
    check("R4 saturated result", result, expCodes(0) - 1);
    check("R4 overrange set", overrange, 1);

    // R6, R9: idle pulses leave the latched outputs alone
    genPer = 4;
    repeat (400) @(negedge clk);
    check("R6 R9 result held while idle", result, expCodes(0) - 1);
    check("R6 overrange held while idle", overrange, 1);

    // R9: pulses stopping just before the gate do not leak in
    genPer = 0; repeat (12) @(negedge clk);
    runConv(3, len);
    check("R9 pre-gate pulses excluded", result, 0);
    check("R4 overrange cleared by new conversion", overrange, 0);

    // R7, R6: starts during the gate, including its last cycle
    genPer = 6; repeat (10) @(negedge clk);
    runConv(0, len);
    held = int'(result);
    start = 1'b1; resSel = 3'd0;
    @(negedge clk);
    start = 1'b0;
    len = 0;
    while (busy) begin
      len++;
      if (len == 100) check("R6 result held during next gate", result, held);
      start = (len == 100 || len == 2 * expCodes(0));
      resSel = start ? 3'd2 : 3'd0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 gate length unchanged by busy start", len, 2 * expCodes(0));
    check("R5 done after ignored starts", done, 1);
    @(negedge clk);
    check("R7 last-cycle start ignored", busy, 0);
    check("R5 done drops", done, 0);
    repeat (5) @(negedge clk);
    check("R7 still idle", busy, 0);

    genPer = 0;
    repeat (10) @(negedge clk);
    finish_up();
  end

endmodule